// File: doc/BRIEF.md
# Free-Running Time Base with Edge Capture

This block keeps a 16-bit time base that starts at zero out of reset and steps up by one every 16 input clocks. Nothing on the register bus can stop it, load it or alter it. Three primary event pins each own a capture register. When the selected edge arrives on a pin, its register takes the time-base value, and an interrupt flag can be raised for that pin.

A general-purpose down-counter and its reload register normally count and reload. When a mode bit is set they stop counting and become two more capture registers, driven by two further event pins. A separate capture path serves one external pin through its own configuration register and its own 16-bit capture register. Every event pin first passes a two-flop synchronizer. The time-base value that gets stored is the one present in the cycle where the synchronized edge is seen.

Software reads and writes the block through a single-cycle register bus. Read data is combinational from the current register state. Interrupt flags drive the `irq` outputs directly. Software clears a flag by writing a 1 to its bit.

Top module: `tbcap_top`

## Requirements
- R1: The time base (read at address 0x0) is 0 after reset and advances by exactly one after every 16 clock cycles, so after m clock edges since reset release it reads m/16 (integer division, modulo 2^16).
- R2: A bus write to address 0x0 leaves the time base unchanged and on its regular schedule.
- R3: A pin change on evt_pin[i] (i = 0..2) first seen by clock edge k, and matching the selected edge, stores the time-base value present after edge k+1 into capture register i at address 0x1+i. The new value is readable from edge k+2 onward. All capture registers read 0 after reset.
- R4: Bit i of the edge register (address 0x4) selects the edge for evt_pin[i]: 0 means rising (0 to 1) and 1 means falling (1 to 0). A change in the other direction neither captures nor sets a flag.
- R5: Bit 4+i of the edge register enables the interrupt for evt_pin[i]. A qualifying edge with the enable set makes flag bit i of the flag register (address 0x5) and irq[i] go to 1 in the same cycle the capture appears. With the enable clear, no flag is set.
- R6: A write to address 0x5 clears each flag whose data bit is 1 and leaves flags whose data bit is 0 as they were.
- R7: With mode register (address 0x6) bit 0 set, the counter register (address 0x7) captures on gp_pin[0] and the reload register (address 0x8) captures on gp_pin[1]. Timing is as in R3. Mode bits 2+j select the edge (0 rising), bits 4+j enable flag 3+j, and bus writes to 0x7 and 0x8 are ignored.
- R8: With mode bit 0 clear, 0x7 and 0x8 are writable. While mode bit 1 is set, the counter decreases by one every clock and, when at 0, loads the reload value instead. In this mode gp_pin edges capture nothing and set no flag.
- R9: The external path captures on ext_pin into address 0xA, timed as in R3. Configuration register 0x9 holds bit 2 (enable), bit 0 (edge, 0 rising) and bit 1 (interrupt enable, flag 5). With bit 2 clear, ext_pin edges capture nothing and set no flag.
- R10: A bus read of a capture register in the cycle whose closing edge stores a new capture returns the old value; the next cycle returns the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, acts on the rising clock edge |
| bus_addr | input | 4 | Register address for reads and writes |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| evt_pin | input | 3 | Primary event pins |
| gp_pin | input | 2 | Event pins for the repurposed counter and reload registers |
| ext_pin | input | 1 | Event pin of the separate external capture path |
| irq | output | 6 | Interrupt flags: 0..2 primary, 3..4 repurposed pair, 5 external |

## Verification
The assertions check on every cycle that the time base steps only on its 16-cycle tick and by exactly one, that every qualified event loads its register with the time base of the previous cycle, that a register with no event holds its value, and that a flag rises only after an enabled event. Only the bench scenarios can show that the edge select rejects the opposite edge, that writes to the time base and to captured registers are ignored, that the write-one-to-clear mask spares flags written with 0, and that a read in the capture cycle still sees the old value. The count-down and reload sequence of the general timer, and the way a disabled external path or timer mode mutes pin events, are also checked only by the scenarios.

// File: rtl/tbcap_pkg.sv
package tbcap_pkg;
  localparam int NPRI = 3;
  localparam int NGP  = 2;
  localparam int NCH  = NPRI + NGP + 1;

  localparam logic [3:0] A_BASE  = 4'h0;
  localparam logic [3:0] A_CAP0  = 4'h1;
  localparam logic [3:0] A_EDGE  = 4'h4;
  localparam logic [3:0] A_FLAG  = 4'h5;
  localparam logic [3:0] A_MODE  = 4'h6;
  localparam logic [3:0] A_GPCNT = 4'h7;
  localparam logic [3:0] A_GPRLD = 4'h8;
  localparam logic [3:0] A_XCFG  = 4'h9;
  localparam logic [3:0] A_XCAP  = 4'hA;

  // field positions
  localparam int EDGE_IEN_LSB = 4;
  localparam int MODE_CAP     = 0;
  localparam int MODE_RUN     = 1;
  localparam int MODE_FALLLSB = 2;
  localparam int MODE_IENLSB  = 4;
  localparam int XCFG_FALL    = 0;
  localparam int XCFG_IEN     = 1;
  localparam int XCFG_EN      = 2;

  // fall = 0 -> rising edge, fall = 1 -> falling edge
  function automatic logic edge_seen(input logic prev, input logic cur, input logic fall);
    return fall ? (prev & ~cur) : (~prev & cur);
  endfunction
endpackage

// File: rtl/tbcap_edge.sv
module tbcap_edge import tbcap_pkg::*; #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic fall_sel,
  output logic hit
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-1:0], pin};
  end

  assign hit = edge_seen(sh_q[STAGES], sh_q[STAGES-1], fall_sel);
endmodule

// File: rtl/tbcap_timebase.sv
module tbcap_timebase #(
  parameter int W   = 16,
  parameter int DIV = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic         tick,
  output logic [W-1:0] base
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] PLAST = PW'(DIV - 1);

  function automatic logic [W-1:0] base_next(input logic [W-1:0] b, input logic t);
    return t ? b + 1'b1 : b;
  endfunction

  logic [PW-1:0] pre_q;

  assign tick = (pre_q == PLAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      base  <= '0;
    end else begin
      pre_q <= tick ? '0 : pre_q + 1'b1;
      base  <= base_next(base, tick);
    end
  end
endmodule

// File: rtl/tbcap_gptimer.sv
module tbcap_gptimer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap_mode,
  input  logic         run,
  input  logic         wr_cnt,
  input  logic         wr_rld,
  input  logic [W-1:0] wdata,
  input  logic         ev_cnt,
  input  logic         ev_rld,
  input  logic [W-1:0] base,
  output logic [W-1:0] cnt,
  output logic [W-1:0] rld
);
  function automatic logic [W-1:0] down_next(input logic [W-1:0] c, input logic [W-1:0] r);
    return (c == '0) ? r : c - 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      rld <= '0;
    end else if (cap_mode) begin
      if (ev_cnt) cnt <= base;
      if (ev_rld) rld <= base;
    end else begin
      if (wr_cnt)   cnt <= wdata;
      else if (run) cnt <= down_next(cnt, rld);
      if (wr_rld)   rld <= wdata;
    end
  end
endmodule

// File: rtl/tbcap_top.sv
module tbcap_top import tbcap_pkg::*; #(
  parameter int W    = 16,
  parameter int DIV  = 16,
  parameter int SYNC = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_wr,
  input  logic [3:0]      bus_addr,
  input  logic [W-1:0]    bus_wdata,
  output logic [W-1:0]    bus_rdata,
  input  logic [NPRI-1:0] evt_pin,
  input  logic [NGP-1:0]  gp_pin,
  input  logic            ext_pin,
  output logic [NCH-1:0]  irq
);
  logic            tb_tick;
  logic [W-1:0]    base_q;
  logic [NPRI-1:0] pri_fall, pri_ien;
  logic            cap_mode, gp_run;
  logic [NGP-1:0]  gp_fall, gp_ien;
  logic            ext_fall, ext_ien, ext_en;
  logic [NCH-1:0]  pin_all, fall_all, ien_all, qual, pin_hit, cap_ev, flag_clr;
  logic [NPRI-1:0][W-1:0] cap_q;
  logic [W-1:0]    ext_cap_q, gp_cnt, gp_rld;

  function automatic logic wsel(input logic wr, input logic [3:0] a, input logic [3:0] t);
    return wr && (a == t);
  endfunction

  tbcap_timebase #(.W(W), .DIV(DIV)) u_base (
    .clk(clk), .rst_n(rst_n), .tick(tb_tick), .base(base_q)
  );

  assign pin_all  = {ext_pin, gp_pin, evt_pin};
  assign fall_all = {ext_fall, gp_fall, pri_fall};
  assign ien_all  = {ext_ien, gp_ien, pri_ien};
  assign qual     = {ext_en, {NGP{cap_mode}}, {NPRI{1'b1}}};

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_edge
      tbcap_edge #(.STAGES(SYNC)) u_edge (
        .clk(clk), .rst_n(rst_n), .pin(pin_all[c]),
        .fall_sel(fall_all[c]), .hit(pin_hit[c])
      );
    end
  endgenerate

  assign cap_ev   = pin_hit & qual;
  assign flag_clr = wsel(bus_wr, bus_addr, A_FLAG) ? bus_wdata[NCH-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pri_fall <= '0; pri_ien <= '0;
      cap_mode <= 1'b0; gp_run <= 1'b0; gp_fall <= '0; gp_ien <= '0;
      ext_fall <= 1'b0; ext_ien <= 1'b0; ext_en <= 1'b0;
      irq      <= '0;
    end else begin
      if (wsel(bus_wr, bus_addr, A_EDGE)) begin
        pri_fall <= bus_wdata[NPRI-1:0];
        pri_ien  <= bus_wdata[EDGE_IEN_LSB +: NPRI];
      end
      if (wsel(bus_wr, bus_addr, A_MODE)) begin
        cap_mode <= bus_wdata[MODE_CAP];
        gp_run   <= bus_wdata[MODE_RUN];
        gp_fall  <= bus_wdata[MODE_FALLLSB +: NGP];
        gp_ien   <= bus_wdata[MODE_IENLSB +: NGP];
      end
      if (wsel(bus_wr, bus_addr, A_XCFG)) begin
        ext_fall <= bus_wdata[XCFG_FALL];
        ext_ien  <= bus_wdata[XCFG_IEN];
        ext_en   <= bus_wdata[XCFG_EN];
      end
      irq <= (irq & ~flag_clr) | (cap_ev & ien_all);
    end
  end

  generate
    for (genvar i = 0; i < NPRI; i++) begin : g_cap
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         cap_q[i] <= '0;
        else if (cap_ev[i]) cap_q[i] <= base_q;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              ext_cap_q <= '0;
    else if (cap_ev[NCH-1])  ext_cap_q <= base_q;
  end

  tbcap_gptimer #(.W(W)) u_gp (
    .clk(clk), .rst_n(rst_n), .cap_mode(cap_mode), .run(gp_run),
    .wr_cnt(wsel(bus_wr, bus_addr, A_GPCNT)),
    .wr_rld(wsel(bus_wr, bus_addr, A_GPRLD)),
    .wdata(bus_wdata), .ev_cnt(cap_ev[NPRI]), .ev_rld(cap_ev[NPRI+1]),
    .base(base_q), .cnt(gp_cnt), .rld(gp_rld)
  );

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_BASE:  bus_rdata = base_q;
      A_CAP0:  bus_rdata = cap_q[0];
      4'h2:    bus_rdata = cap_q[1];
      4'h3:    bus_rdata = cap_q[2];
      A_EDGE: begin
        bus_rdata[NPRI-1:0]             = pri_fall;
        bus_rdata[EDGE_IEN_LSB +: NPRI] = pri_ien;
      end
      A_FLAG:  bus_rdata[NCH-1:0] = irq;
      A_MODE: begin
        bus_rdata[MODE_CAP]             = cap_mode;
        bus_rdata[MODE_RUN]             = gp_run;
        bus_rdata[MODE_FALLLSB +: NGP]  = gp_fall;
        bus_rdata[MODE_IENLSB +: NGP]   = gp_ien;
      end
      A_GPCNT: bus_rdata = gp_cnt;
      A_GPRLD: bus_rdata = gp_rld;
      A_XCFG: begin
        bus_rdata[XCFG_FALL] = ext_fall;
        bus_rdata[XCFG_IEN]  = ext_ien;
        bus_rdata[XCFG_EN]   = ext_en;
      end
      A_XCAP:  bus_rdata = ext_cap_q;
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/tbcap_chk.sv
module tbcap_chk import tbcap_pkg::*; #(
  parameter int W   = 16,
  parameter int DIV = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   tick,
  input logic [W-1:0]           base,
  input logic [NCH-1:0]         ev,
  input logic [NCH-1:0]         ien,
  input logic [NCH-1:0]         flags,
  input logic [NPRI-1:0][W-1:0] cap,
  input logic [W-1:0]           ext_cap,
  input logic [W-1:0]           gp_cnt,
  input logic [W-1:0]           gp_rld
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  logic [PW-1:0] per_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    per_q <= '0;
    else if (per_q == PW'(DIV-1))  per_q <= '0;
    else                           per_q <= per_q + 1'b1;
  end

  // R1
  tick_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick == (per_q == PW'(DIV-1)));
  // R1
  base_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> base == $past(base) + 1'b1);
  // R1
  base_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(base));

  generate
    for (genvar i = 0; i < NPRI; i++) begin : g_pri
      // R3
      cap_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev[i] |=> cap[i] == $past(base));
      // R3
      cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ev[i] |=> $stable(cap[i]));
    end
    for (genvar c = 0; c < NCH; c++) begin : g_flag
      // R5
      flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev[c] && ien[c]) |=> flags[c]);
      // R5
      flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[c]) |-> $past(ev[c] && ien[c]));
    end
  endgenerate

  // R7
  gp_cnt_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev[NPRI] |=> gp_cnt == $past(base));
  // R7
  gp_rld_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev[NPRI+1] |=> gp_rld == $past(base));
  // R9
  ext_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev[NCH-1] |=> ext_cap == $past(base));
  // R9
  ext_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ev[NCH-1] |=> $stable(ext_cap));
endmodule

bind tbcap_top tbcap_chk #(.W(W), .DIV(DIV)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tb_tick), .base(base_q),
  .ev(cap_ev), .ien(ien_all), .flags(irq), .cap(cap_q),
  .ext_cap(ext_cap_q), .gp_cnt(gp_cnt), .gp_rld(gp_rld)
);

// File: tb/tbcap_top_tb.sv
module tbcap_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = 4'h0;
  logic [15:0] bus_wdata = 16'h0;
  logic [15:0] bus_rdata;
  logic [2:0]  evt_pin = 3'b0;
  logic [1:0]  gp_pin = 2'b0;
  logic        ext_pin = 1'b0;
  logic [5:0]  irq;

  tbcap_top u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_pin(evt_pin),
    .gp_pin(gp_pin), .ext_pin(ext_pin), .irq(irq)
  );

  always #4 clk = ~clk;

  int total = 0;
  int bad = 0;
  int ncyc = 0;
  int rd_m = 0;
  bit done = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) ncyc <= 0;
    else        ncyc <= ncyc + 1;
  end

  // bench-side model state
  logic [5:0]  lvl = 6'b0;
  logic [5:0]  fall_b = 6'b0;
  logic [5:0]  ien_b = 6'b0;
  logic        xen_b = 1'b0;
  logic        capm_b = 1'b0;
  logic [15:0] exp_cap [6];
  logic [5:0]  exp_flags = 6'b0;

  function automatic logic [15:0] exp_base(input int n);
    return 16'((n / 16) % 65536);
  endfunction

  function automatic logic edge_match(input logic o, input logic nw, input logic f);
    return f ? (o && !nw) : (!o && nw);
  endfunction

  function automatic logic [3:0] ch_addr(input int ch);
    case (ch)
      0: return 4'h1;
      1: return 4'h2;
      2: return 4'h3;
      3: return 4'h7;
      4: return 4'h8;
      default: return 4'hA;
    endcase
  endfunction

  function automatic logic ch_live(input int ch);
    if (ch < 3)  return 1'b1;
    if (ch < 5)  return capm_b;
    return xen_b;
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a;
    #1;
    d = bus_rdata;
    rd_m = ncyc;
  endtask

  task automatic drive(input logic [5:0] nl);
    int n;
    @(negedge clk);
    n = ncyc;
    for (int ch = 0; ch < 6; ch++) begin
      if (ch_live(ch) && edge_match(lvl[ch], nl[ch], fall_b[ch])) begin
        exp_cap[ch] = exp_base(n + 2);
        if (ien_b[ch]) exp_flags[ch] = 1'b1;
      end
    end
    evt_pin = nl[2:0]; gp_pin = nl[4:3]; ext_pin = nl[5];
    lvl = nl;
  endtask

  task automatic check_caps(input string tag);
    logic [15:0] d;
    for (int ch = 0; ch < 6; ch++) begin
      if (ch_live(ch)) begin
        rd(ch_addr(ch), d);
        chk(tag, d, exp_cap[ch]);
      end
    end
  endtask

  task automatic check_flags(input string tag);
    logic [15:0] d;
    rd(4'h5, d);
    chk(tag, d, {10'b0, exp_flags});
    chk(tag, {10'b0, irq}, {10'b0, exp_flags});
  endtask

  task automatic summary;
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    logic [15:0] d;
    logic [15:0] old;
    logic [5:0]  nl;
    logic [5:0]  mask;
    int q;
    void'($urandom(32'h5eed_1234));
    for (int ch = 0; ch < 6; ch++) exp_cap[ch] = 16'h0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state
    rd(4'h0, d); chk("R1 base after reset", d, exp_base(rd_m));
    for (int i = 0; i < 3; i++) begin
      rd(ch_addr(i), d); chk("R3 capture reset value", d, 16'h0);
    end
    check_flags("R5 flags after reset");

    // time base rate
    for (int k = 0; k < 6; k++) begin
      repeat ($urandom_range(30, 5)) @(negedge clk);
      rd(4'h0, d); chk("R1 base rate", d, exp_base(rd_m));
    end
    wr(4'h0, 16'hFFFF);
    rd(4'h0, d); chk("R2 base write ignored", d, exp_base(rd_m));
    wr(4'h0, 16'h0000);
    repeat (17) @(negedge clk);
    rd(4'h0, d); chk("R2 base write ignored later", d, exp_base(rd_m));

    // random configuration and pin activity
    fall_b[2:0] = 3'($urandom);
    ien_b[2:0]  = 3'($urandom);
    fall_b[5]   = 1'($urandom);
    ien_b[5]    = 1'b1;
    xen_b       = 1'b1;
    wr(4'h4, {9'b0, ien_b[2:0], 1'b0, fall_b[2:0]});
    wr(4'h9, {13'b0, xen_b, ien_b[5], fall_b[5]});
    for (int s = 0; s < 48; s++) begin
      nl = 6'($urandom);
      drive(nl);
      repeat ($urandom_range(8, 4)) @(negedge clk);
      check_caps("R3 R4 R9 random capture");
      check_flags("R5 random flags");
      if (s % 6 == 5) begin
        mask = 6'($urandom);
        wr(4'h5, {10'b0, mask});
        exp_flags = exp_flags & ~mask;
        check_flags("R6 write one to clear");
      end
      if (s == 20) begin
        fall_b[2:0] = ~fall_b[2:0];
        wr(4'h4, {9'b0, ien_b[2:0], 1'b0, fall_b[2:0]});
      end
    end
    rd(4'h5, d); chk("R8 gp pins ignored in timer mode", {14'b0, d[4:3]}, 16'h0);

    // read during capture cycle returns old value
    drive(6'b000000);
    repeat (6) @(negedge clk);
    fall_b[2:0] = 3'b000; ien_b[2:0] = 3'b111;
    wr(4'h4, 16'h0070);
    repeat (20) @(negedge clk);
    check_caps("R3 settle");
    old = exp_cap[0];
    drive(6'b000001);
    @(negedge clk);
    rd(4'h1, d); chk("R10 read in capture cycle is old", d, old);
    rd(4'h1, d); chk("R10 read after capture is new", d, exp_cap[0]);
    chk("R10 new differs from old", {15'b0, (exp_cap[0] != old)}, 16'h1);
    check_flags("R5 flag after directed capture");

    // disabled external path ignores its pin
    wr(4'h5, 16'h003F); exp_flags = 6'b0;
    xen_b = 1'b0;
    wr(4'h9, 16'h0002);
    old = exp_cap[5];
    drive(6'b100001);
    repeat (20) @(negedge clk);
    drive(6'b000001);
    repeat (6) @(negedge clk);
    rd(4'hA, d); chk("R9 disabled path ignores pin", d, old);
    check_flags("R9 disabled path raises no flag");

    // general timer counting
    wr(4'h8, 16'd5);
    wr(4'h7, 16'd3);
    rd(4'h7, d); chk("R8 counter writable", d, 16'd3);
    wr(4'h6, 16'h0002);
    q = ncyc;
    for (int t = 0; t < 3; t++) begin
      logic [15:0] v;
      repeat ($urandom_range(9, 1)) @(negedge clk);
      rd(4'h7, d);
      v = 16'd3;
      for (int k = 0; k < rd_m - q; k++) v = (v == 16'd0) ? 16'd5 : v - 16'd1;
      chk("R8 count down and reload", d, v);
    end
    drive(6'b011001);
    repeat (6) @(negedge clk);
    rd(4'h5, d); chk("R8 gp edge ignored in timer mode", {14'b0, d[4:3]}, 16'h0);
    drive(6'b000001);
    repeat (6) @(negedge clk);

    // capture mode for the counter pair, rising edges, interrupts on
    capm_b = 1'b1; fall_b[4:3] = 2'b00; ien_b[4:3] = 2'b11;
    wr(4'h6, 16'h0031);
    repeat (20) @(negedge clk);
    drive(6'b011001);
    repeat (6) @(negedge clk);
    check_caps("R7 counter pair capture");
    check_flags("R7 counter pair flags");
    wr(4'h7, 16'h1234);
    wr(4'h8, 16'h4321);
    rd(4'h7, d); chk("R7 counter write ignored", d, exp_cap[3]);
    rd(4'h8, d); chk("R7 reload write ignored", d, exp_cap[4]);
    repeat (20) @(negedge clk);
    drive(6'b000001);
    repeat (6) @(negedge clk);
    check_caps("R7 falling edge ignored");

    summary();
  end
endmodule